// File: doc/BRIEF.md
# Single-Bit Memory Operation Unit

This unit carries out one-bit operations for a small core whose data memory is four bits wide. When it accepts a request, it decodes an operation code and an addressing mode. From these it forms a byte address and a bit index. It then reads the addressed word through a synchronous memory port and finishes the operation in the following cycle. The operation can force the bit to one, force it to zero, test it and ask the core to skip, test it and clear it when it was set, or fold it into the carry flag with AND, OR or XOR.

The surrounding core keeps the carry flag and the H and L registers. It presents all of them with the request, and it takes back a carry update strobe and a skip request. Fetching instructions and carrying out the skip remain the core's job.

Top module: `bitop_unit`

## Requirements
- R1: Operation code 0 (set) writes the addressed word back with the selected bit at 1 and the other three bits unchanged. It requests no skip and no carry update.
- R2: Operation code 1 (clear) writes the addressed word back with the selected bit at 0 and the other bits unchanged. It requests no skip and no carry update.
- R3: Operation code 2 requests a skip when the bit is 1, and operation code 3 requests a skip when the bit is 0. Neither writes memory or updates carry.
- R4: Operation code 4 (skip-and-clear) works as follows. When the bit is 1, it requests a skip and writes the word back with that bit at 0. When the bit is 0, it requests no skip and performs no write.
- R5: Operation codes 5, 6 and 7 assert the carry update strobe. The new carry is the incoming carry AND, OR or XOR the bit, in that code order. These operations never write memory and never request a skip.
- R6: Mode 0 (direct) uses the 8-bit memory field as the address and the immediate bit field as the index. Mode 1 (fixed area) uses the address {4'hF, field[3:0]} with the immediate index.
- R7: Mode 2 (L-indirect) uses the address {field[7:2], L[3:2]} and takes the bit index from L[1:0]. The immediate bit field is ignored in this mode.
- R8: Mode 3 (H-indirect) uses the address {H, field[3:0]} with the immediate bit index.
- R9: Operation codes 4 to 7 in mode 0 are illegal. Such a request raises the error flag at completion, performs no read and no write, updates no carry and requests no skip.
- R10: The completion strobe is high in exactly the second cycle after the accepting edge. Requests raised while an operation is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Request; accepted when the unit is idle |
| op | input | 3 | Operation code |
| mode | input | 2 | Addressing mode |
| bit_sel | input | 2 | Immediate bit index |
| mem_field | input | 8 | Immediate memory operand field |
| h_reg | input | 4 | H register value |
| l_reg | input | 4 | L register value |
| cy_in | input | 1 | Current carry flag |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | 8 | Memory address |
| mem_rdata | input | 4 | Read data, valid the cycle after mem_re |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 4 | Write data |
| cy_we | output | 1 | Carry update strobe |
| cy_next | output | 1 | New carry value |
| skip | output | 1 | Skip request |
| done | output | 1 | Operation complete |
| err | output | 1 | Illegal mode and operation pair, valid with done |

## Verification
The unit registers the request on the accepting edge and reads memory on the next edge. Every result (write strobe and data, skip, carry update, error) appears together with done in the cycle after the read, which is two edges after acceptance. The driver records the cycle count at the accepting edge and queues the expected result tagged as due one count later. The monitor samples on the falling edge, pops an entry only when done is high, and compares both the cycle number and every output against that entry. A second request is also raised while an operation is busy, and the bench then confirms that it produces no extra completion.

// File: rtl/bitop_unit.sv
module bitop_unit #(
  parameter int HW = 4,
  parameter int DW = 4,
  parameter logic [HW-1:0] FIX_HI = '1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [2:0]             op,
  input  logic [1:0]             mode,
  input  logic [$clog2(DW)-1:0]  bit_sel,
  input  logic [2*HW-1:0]        mem_field,
  input  logic [HW-1:0]          h_reg,
  input  logic [HW-1:0]          l_reg,
  input  logic                   cy_in,
  output logic                   mem_re,
  output logic [2*HW-1:0]        mem_addr,
  input  logic [DW-1:0]          mem_rdata,
  output logic                   mem_we,
  output logic [DW-1:0]          mem_wdata,
  output logic                   cy_we,
  output logic                   cy_next,
  output logic                   skip,
  output logic                   done,
  output logic                   err
);
  localparam int AW = 2*HW;
  localparam int BW = $clog2(DW);

  localparam logic [2:0] OP_SET = 3'd0, OP_CLR = 3'd1, OP_SKT = 3'd2, OP_SKF = 3'd3,
                         OP_SKC = 3'd4, OP_AND = 3'd5, OP_OR  = 3'd6, OP_XOR = 3'd7;
  localparam logic [1:0] MD_DIR = 2'd0, MD_FIX = 2'd1, MD_LIND = 2'd2, MD_HIND = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_EX} st_t;
  st_t st;

  logic [AW-1:0] ea, a_q;
  logic [BW-1:0] eb, b_q;
  logic [2:0]    op_q;
  logic          bad_q;
  logic          accept, bad_in, live, tbit;
  logic [DW-1:0] mask;

  assign accept = start && (st == S_IDLE);
  assign bad_in = (mode == MD_DIR) && op[2];

  always_comb begin
    ea = mem_field;
    eb = bit_sel;
    case (mode)
      MD_FIX:  ea = {FIX_HI, mem_field[HW-1:0]};
      MD_LIND: begin
        ea = {mem_field[AW-1:2], l_reg[BW+1:BW]};
        eb = l_reg[BW-1:0];
      end
      MD_HIND: ea = {h_reg, mem_field[HW-1:0]};
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      a_q <= '0;
      b_q <= '0;
      op_q <= OP_SET;
      bad_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          st <= S_RD;
          a_q <= ea;
          b_q <= eb;
          op_q <= op;
          bad_q <= bad_in;
        end
        S_RD:    st <= S_EX;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_re   = (st == S_RD) && !bad_q;
  assign mem_addr = a_q;
  assign done     = (st == S_EX);
  assign err      = done && bad_q;
  assign live     = done && !bad_q;
  assign tbit     = mem_rdata[b_q];
  assign mask     = {{(DW-1){1'b0}}, 1'b1} << b_q;

  assign mem_we    = live && ((op_q == OP_SET) || (op_q == OP_CLR) || ((op_q == OP_SKC) && tbit));
  assign mem_wdata = (op_q == OP_SET) ? (mem_rdata | mask) : (mem_rdata & ~mask);
  assign skip      = live && (((op_q == OP_SKT) && tbit) || ((op_q == OP_SKF) && !tbit) ||
                              ((op_q == OP_SKC) && tbit));
  assign cy_we     = live && ((op_q == OP_AND) || (op_q == OP_OR) || (op_q == OP_XOR));

  always_comb begin
    case (op_q)
      OP_AND:  cy_next = cy_in & tbit;
      OP_OR:   cy_next = cy_in | tbit;
      OP_XOR:  cy_next = cy_in ^ tbit;
      default: cy_next = cy_in;
    endcase
  end

  assert_one_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($countones(mem_wdata ^ mem_rdata) <= 1));
  assert_skc_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && op_q == OP_SKC) |-> skip);
  assert_cy_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cy_we |-> (!mem_we && !skip));
  assert_err_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!mem_we && !cy_we && !skip));
  assert_no_read_bad_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !$past(mem_re));
  assert_done_lat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(accept, 2));
  assert_read_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> $past(mem_re));
endmodule

// File: tb/sim_bitop_unit.sv
`timescale 1ns/1ps
module sim_bitop_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] op = '0;
  logic [1:0] mode = '0, bit_sel = '0;
  logic [7:0] mem_field = '0;
  logic [3:0] h_reg = '0, l_reg = '0;
  logic cy_in = 1'b0;
  logic mem_re, mem_we, cy_we, cy_next, skip, done, err;
  logic [7:0] mem_addr;
  logic [3:0] mem_rdata, mem_wdata;

  bitop_unit u0 (.clk(clk), .rst_n(rst_n), .start(start), .op(op), .mode(mode),
    .bit_sel(bit_sel), .mem_field(mem_field), .h_reg(h_reg), .l_reg(l_reg), .cy_in(cy_in),
    .mem_re(mem_re), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .cy_we(cy_we), .cy_next(cy_next), .skip(skip), .done(done), .err(err));

  always #2 clk = ~clk;

  logic [3:0] ram [256];
  logic [3:0] shadow [256];
  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_re) mem_rdata <= ram[mem_addr];
    if (mem_we) ram[mem_addr] <= mem_wdata;
  end

  typedef struct packed {
    logic       e_err;
    logic [7:0] e_addr;
    logic       e_we;
    logic [3:0] e_wd;
    logic       e_skip;
    logic       e_cyw;
    logic       e_cy;
    logic [31:0] due;
  } exp_t;
  exp_t q [$];
  string tq [$];
  int nchk = 0, nfail = 0, ndone = 0, npush = 0;

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && done) begin
    exp_t e;
    string t;
    ndone++;
    if (q.size() == 0) chk(1'b0, "R10", "unexpected done", 1, 0);
    else begin
      e = q.pop_front();
      t = tq.pop_front();
      chk(cyc == int'(e.due), "R10", "done cycle", cyc, e.due);
      chk(err == e.e_err, "R9", "err", err, e.e_err);
      if (e.e_err) begin
        chk(!mem_we && !cy_we && !skip, "R9", "quiet on error", {mem_we, cy_we, skip}, 0);
      end else begin
        chk(mem_addr == e.e_addr, t, "address", mem_addr, e.e_addr);
        chk(mem_we == e.e_we, t, "write strobe", mem_we, e.e_we);
        if (e.e_we) chk(mem_wdata == e.e_wd, t, "write data", mem_wdata, e.e_wd);
        chk(skip == e.e_skip, t, "skip", skip, e.e_skip);
        chk(cy_we == e.e_cyw, t, "carry strobe", cy_we, e.e_cyw);
        if (e.e_cyw) chk(cy_next == e.e_cy, t, "carry", cy_next, e.e_cy);
      end
    end
  end

  task automatic run(input logic [2:0] o, input logic [1:0] m, input logic [1:0] b,
                     input logic [7:0] f, input logic [3:0] h, input logic [3:0] l,
                     input logic c, input string tag, input bit poke_busy);
    exp_t e;
    logic [7:0] a;
    logic [1:0] bi;
    logic tb;
    a = f;
    bi = b;
    case (m)
      2'd1: a = {4'hF, f[3:0]};
      2'd2: begin a = {f[7:2], l[3:2]}; bi = l[1:0]; end
      2'd3: a = {h, f[3:0]};
      default: ;
    endcase
    tb = shadow[a][bi];
    e = '0;
    e.e_err = (m == 2'd0) && o[2];
    e.e_addr = a;
    if (!e.e_err) begin
      case (o)
        3'd0: begin e.e_we = 1; e.e_wd = shadow[a] | (4'b1 << bi); end
        3'd1: begin e.e_we = 1; e.e_wd = shadow[a] & ~(4'b1 << bi); end
        3'd2: e.e_skip = tb;
        3'd3: e.e_skip = !tb;
        3'd4: begin e.e_skip = tb; e.e_we = tb; e.e_wd = shadow[a] & ~(4'b1 << bi); end
        3'd5: begin e.e_cyw = 1; e.e_cy = c & tb; end
        3'd6: begin e.e_cyw = 1; e.e_cy = c | tb; end
        default: begin e.e_cyw = 1; e.e_cy = c ^ tb; end
      endcase
      if (e.e_we) shadow[a] = e.e_wd;
    end
    op = o; mode = m; bit_sel = b; mem_field = f; h_reg = h; l_reg = l; cy_in = c;
    start = 1'b1;
    @(posedge clk);
    #1;
    e.due = cyc + 1;
    q.push_back(e);
    tq.push_back(tag);
    npush++;
    @(negedge clk);
    if (poke_busy) begin
      op = 3'd0; mode = 2'd3; bit_sel = 2'd3; h_reg = 4'h0; mem_field = 8'h00;
    end else start = 1'b0;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(4.0 * 200000);
    nfail++;
    $display("FAIL R10 watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      ram[i] = 4'(i * 7 + 3);
      shadow[i] = 4'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    chk(!done && !mem_we && !mem_re && !skip && !cy_we && !err, "R10", "reset outputs",
        {done, mem_we, mem_re, skip, cy_we, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run(3'd0, 2'd0, 2'd2, 8'h35, 4'h0, 4'h0, 1'b0, "R1", 0);
    run(3'd0, 2'd0, 2'd2, 8'h35, 4'h0, 4'h0, 1'b0, "R1", 0);
    run(3'd1, 2'd1, 2'd1, 8'h27, 4'h0, 4'h0, 1'b0, "R2", 0);
    run(3'd1, 2'd1, 2'd0, 8'hA6, 4'h0, 4'h0, 1'b0, "R6", 0);
    run(3'd2, 2'd0, 2'd2, 8'h35, 4'h0, 4'h0, 1'b0, "R3", 0);
    run(3'd3, 2'd0, 2'd2, 8'h35, 4'h0, 4'h0, 1'b0, "R3", 0);
    run(3'd3, 2'd3, 2'd1, 8'h0C, 4'h9, 4'h0, 1'b0, "R8", 0);
    run(3'd0, 2'd2, 2'd0, 8'h54, 4'h0, 4'hB, 1'b0, "R7", 0);
    run(3'd4, 2'd2, 2'd1, 8'h54, 4'h0, 4'hB, 1'b0, "R4", 0);
    run(3'd4, 2'd2, 2'd1, 8'h54, 4'h0, 4'hB, 1'b0, "R4", 0);
    run(3'd2, 2'd2, 2'd3, 8'h57, 4'h0, 4'h4, 1'b0, "R7", 0);
    run(3'd5, 2'd1, 2'd0, 8'h03, 4'h0, 4'h0, 1'b1, "R5", 0);
    run(3'd6, 2'd3, 2'd3, 8'h01, 4'h7, 4'h0, 1'b0, "R5", 0);
    run(3'd7, 2'd2, 2'd0, 8'hC8, 4'h0, 4'h6, 1'b1, "R5", 0);
    run(3'd4, 2'd0, 2'd0, 8'h35, 4'h0, 4'h0, 1'b0, "R9", 0);
    run(3'd5, 2'd0, 2'd1, 8'h35, 4'h0, 4'h0, 1'b1, "R9", 0);
    run(3'd7, 2'd0, 2'd3, 8'h10, 4'h0, 4'h0, 1'b0, "R9", 0);
    run(3'd2, 2'd1, 2'd2, 8'h4E, 4'h0, 4'h0, 1'b0, "R10", 1);
    run(3'd2, 2'd3, 2'd3, 8'h00, 4'h0, 4'h0, 1'b0, "R10", 0);
    for (int k = 0; k < 300; k++)
      run(3'($urandom), 2'($urandom), 2'($urandom), 8'($urandom), 4'($urandom),
          4'($urandom), 1'($urandom), "R6", 0);
    repeat (4) @(negedge clk);
    chk(q.size() == 0 && ndone == npush, "R10", "completions vs requests", ndone, npush);
    for (int i = 0; i < 256; i++)
      if (ram[i] != shadow[i]) chk(1'b0, "R1", "memory word", ram[i], shadow[i]);
    chk(1'b1, "R2", "memory image compared", 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule